// File: doc/BRIEF.md
# Prioritized DRAM Refresh Request Queue

This block generates refresh requests for a DRAM controller from a free-running interval timer. Each time the timer expires, one refresh becomes pending. Pending refreshes are held in a counter that can bank up to seven of them. While refreshes are pending, the block asserts a request to the memory arbiter together with a 2-bit urgency. The urgency rises as the backlog grows, so the arbiter can delay refresh behind normal traffic until the backlog becomes dangerous.

The DRAM sequencer returns a one-cycle acknowledge for each refresh it completes. Each acknowledge removes one pending entry. The timer interval comes from an input, so software can match it to the core clock. For example, 1030 cycles at 66 MHz gives one refresh per 15.6 µs.

The backlog can be switched off with an enable input. When it is off, the queue no longer grades urgency: any pending refresh is requested at high urgency immediately. If the timer expires while the queue is already full, the expiry is lost and a sticky overflow flag records it.

Top module: `refresh_queue_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `req`, `prio` and `overflow` are all 0. Reset also restarts the interval timer from zero.
- R2: The timer expires once every `reload_val` clock cycles (`reload_val` ≥ 2). The first expiry after reset is released takes effect on the `reload_val`-th rising edge.
- R3: Each timer expiry adds one pending refresh, up to a maximum of 7.
- R4: With `queue_en` = 1, `prio` encodes urgency as 0 = none, 1 = low, 2 = medium, 3 = high. A pending count of 1 to 3 gives 1, 4 to 6 gives 2, and 7 gives 3.
- R5: With `queue_en` = 0, any nonzero pending count gives `prio` = 3.
- R6: Each cycle with `ack` high and no expiry lowers a nonzero pending count by one. When the count reaches zero, `req` and `prio` both drop to 0.
- R7: An `ack` while nothing is pending has no effect. The count does not wrap.
- R8: When an expiry and an `ack` fall in the same cycle, a nonzero count is unchanged and a zero count becomes 1.
- R9: An expiry without `ack` while 7 refreshes are pending keeps the count at 7 and sets `overflow`. `overflow` stays set until reset, even after acknowledges.
- R10: `req` is high exactly when the pending count is nonzero, which is also exactly when `prio` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_val | input | TIMER_W (11) | Refresh interval in clock cycles |
| queue_en | input | 1 | 1 = grade urgency by backlog, 0 = every pending refresh is high urgency |
| ack | input | 1 | One-cycle pulse: the sequencer finished one refresh |
| req | output | 1 | Refresh request to the arbiter |
| prio | output | 2 | Request urgency: 0 none, 1 low, 2 medium, 3 high |
| overflow | output | 1 | Sticky flag: an expiry was lost because the queue was full |

## Verification
The bench builds the block with its default parameters: an 11-bit timer, a depth of 7 and a medium threshold of 4. It drives `reload_val` with 4 for most tests, so the queue fills and overflows within a few dozen cycles. For the drain and empty-acknowledge tests it uses 2000 instead, which leaves room for several acknowledges between expiries. With the short interval, acknowledge bursts can be placed so that one lands exactly on an expiry edge.

// File: rtl/refq_pkg.sv
package refq_pkg;

    typedef enum logic [1:0] {
        URG_NONE = 2'd0,
        URG_LOW  = 2'd1,
        URG_MED  = 2'd2,
        URG_HIGH = 2'd3
    } refq_urg_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_INC,
        CNT_DEC,
        CNT_SAT
    } refq_step_e;

    function automatic refq_urg_e urg_of_fill(input int unsigned fill,
                                              input logic        graded,
                                              input int unsigned depth,
                                              input int unsigned med_at);
        if (fill == 0)          return URG_NONE;
        else if (!graded)       return URG_HIGH;
        else if (fill >= depth) return URG_HIGH;
        else if (fill >= med_at) return URG_MED;
        else                    return URG_LOW;
    endfunction

    function automatic refq_step_e step_of(input logic expire,
                                           input logic done,
                                           input logic empty,
                                           input logic full);
        if (expire && !done)      return full ? CNT_SAT : CNT_INC;
        else if (expire && done)  return empty ? CNT_INC : CNT_HOLD;
        else if (done && !empty)  return CNT_DEC;
        else                      return CNT_HOLD;
    endfunction

endpackage

// File: rtl/refq_timer.sv
module refq_timer #(
    parameter int TIMER_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIMER_W-1:0] interval,
    output logic               expire
);
    logic [TIMER_W-1:0] ticks_q;
    logic [TIMER_W-1:0] last_tick;

    assign last_tick = interval - TIMER_W'(1);
    assign expire    = (ticks_q >= last_tick);

    always_ff @(posedge clk) begin
        if (rst)         ticks_q <= '0;
        else if (expire) ticks_q <= '0;
        else             ticks_q <= ticks_q + TIMER_W'(1);
    end
endmodule

// File: rtl/refq_backlog.sv
module refq_backlog
    import refq_pkg::*;
#(
    parameter int DEPTH = 7,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  logic             done,
    output logic [CNT_W-1:0] fill,
    output logic             lost
);
    logic       empty, full;
    refq_step_e step;

    assign empty = (fill == '0);
    assign full  = (fill == CNT_W'(DEPTH));
    assign step  = step_of(expire, done, empty, full);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            lost <= 1'b0;
        end else begin
            unique case (step)
                CNT_INC:  fill <= fill + CNT_W'(1);
                CNT_DEC:  fill <= fill - CNT_W'(1);
                CNT_SAT:  lost <= 1'b1;
                default:  fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/refq_grade.sv
module refq_grade
    import refq_pkg::*;
#(
    parameter int DEPTH  = 7,
    parameter int MED_AT = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] fill,
    input  logic             graded,
    output refq_urg_e        urg
);
    always_comb begin
        urg = urg_of_fill(int'(unsigned'(fill)), graded, DEPTH, MED_AT);
    end
endmodule

// File: rtl/refresh_queue_top.sv
module refresh_queue_top
    import refq_pkg::*;
#(
    parameter int TIMER_W = 11,
    parameter int DEPTH   = 7,
    parameter int MED_AT  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [TIMER_W-1:0] reload_val,
    input  logic               queue_en,
    input  logic               ack,
    output logic               req,
    output logic [1:0]         prio,
    output logic               overflow
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             expire;
    logic [CNT_W-1:0] fill;
    refq_urg_e        urg;

    refq_timer #(.TIMER_W(TIMER_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .interval (reload_val),
        .expire   (expire)
    );

    refq_backlog #(.DEPTH(DEPTH)) backlog_i (
        .clk    (clk),
        .rst    (rst),
        .expire (expire),
        .done   (ack),
        .fill   (fill),
        .lost   (overflow)
    );

    refq_grade #(.DEPTH(DEPTH), .MED_AT(MED_AT)) grade_i (
        .fill   (fill),
        .graded (queue_en),
        .urg    (urg)
    );

    assign req  = (fill != '0);
    assign prio = urg;
endmodule

// File: rtl/refq_checker.sv
module refq_checker (
    input logic       clk,
    input logic       rst,
    input logic       queue_en,
    input logic       ack,
    input logic       req,
    input logic [1:0] prio,
    input logic       overflow
);
    // R1: the cycle after reset shows an idle block
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!req && prio == 2'd0 && !overflow));

    // R5: with the queue off, every request is high urgency
    a_r5_disabled_high: assert property (@(posedge clk) disable iff (rst)
        (!queue_en && req) |-> (prio == 2'd3));

    // R9: overflow is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R9: a fresh overflow only happens with a full queue
    a_r9_ovf_full: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> (req && prio == 2'd3));

    // R10: request and urgency agree
    a_r10_req_prio: assert property (@(posedge clk) disable iff (rst)
        req == (prio != 2'd0));

    // R7: acknowledging an empty queue never raises urgency above low
    a_r7_empty_ack: assert property (@(posedge clk) disable iff (rst)
        (!req && ack && queue_en) |=> (prio <= 2'd1));
endmodule

bind refresh_queue_top refq_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .queue_en (queue_en),
    .ack      (ack),
    .req      (req),
    .prio     (prio),
    .overflow (overflow)
);

// File: tb/refresh_queue_top_tb_top.sv
module refresh_queue_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TIMER_W    = 11;
    localparam int WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [TIMER_W-1:0] reload_val = 11'd4;
    logic               queue_en = 1'b1;
    logic               ack = 1'b0;
    logic               req;
    logic [1:0]         prio;
    logic               overflow;

    int n_checks = 0;
    int n_fails  = 0;

    refresh_queue_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .reload_val (reload_val),
        .queue_en   (queue_en),
        .ack        (ack),
        .req        (req),
        .prio       (prio),
        .overflow   (overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {queue_en, expiries waited, req, prio, overflow}
    localparam logic [8:0] VEC [13] = '{
        {1'b1, 4'd0, 1'b0, 2'd0, 1'b0},
        {1'b1, 4'd1, 1'b1, 2'd1, 1'b0},
        {1'b1, 4'd2, 1'b1, 2'd1, 1'b0},
        {1'b1, 4'd3, 1'b1, 2'd1, 1'b0},
        {1'b1, 4'd4, 1'b1, 2'd2, 1'b0},
        {1'b1, 4'd5, 1'b1, 2'd2, 1'b0},
        {1'b1, 4'd6, 1'b1, 2'd2, 1'b0},
        {1'b1, 4'd7, 1'b1, 2'd3, 1'b0},
        {1'b1, 4'd8, 1'b1, 2'd3, 1'b1},
        {1'b0, 4'd0, 1'b0, 2'd0, 1'b0},
        {1'b0, 4'd1, 1'b1, 2'd3, 1'b0},
        {1'b0, 4'd5, 1'b1, 2'd3, 1'b0},
        {1'b0, 4'd8, 1'b1, 2'd3, 1'b1}
    };

    task automatic check(input string tag, input logic e_req,
                         input logic [1:0] e_prio, input logic e_ovf);
        n_checks++;
        if (req !== e_req || prio !== e_prio || overflow !== e_ovf) begin
            n_fails++;
            $display("FAIL %s: req/prio/ovf = %b/%0d/%b, expected %b/%0d/%b",
                     tag, req, prio, overflow, e_req, e_prio, e_ovf);
        end
    endtask

    task automatic restart(input logic [TIMER_W-1:0] r, input logic en);
        @(negedge clk);
        rst = 1'b1;
        ack = 1'b0;
        reload_val = r;
        queue_en = en;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acks(input int n);
        ack = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    initial begin
        // R1: state during reset
        repeat (2) @(negedge clk);
        check("R1 in reset", 1'b0, 2'd0, 1'b0);

        // Table: fill levels reached by waiting whole intervals (R3 R4 R5 R9)
        for (int i = 0; i < 13; i++) begin
            restart(11'd4, VEC[i][8]);
            edges(int'(VEC[i][7:4]) * 4);
            check($sformatf("R3/R4/R5/R9 row %0d", i), VEC[i][3], VEC[i][2:1], VEC[i][0]);
        end

        // R2: no request one edge early, request on the interval edge
        restart(11'd4, 1'b1);
        edges(3);
        check("R2 before expiry", 1'b0, 2'd0, 1'b0);
        edges(1);
        check("R2 at expiry", 1'b1, 2'd1, 1'b0);

        // R6: acknowledges step urgency down from medium to low
        restart(11'd4, 1'b1);
        edges(20);
        acks(1);
        check("R6 fill 4", 1'b1, 2'd2, 1'b0);
        acks(2);
        check("R6 fill 2", 1'b1, 2'd1, 1'b0);

        // R6 drain to zero, then R7 ack on empty does not wrap
        restart(11'd2000, 1'b1);
        edges(2000);
        check("R6 one pending", 1'b1, 2'd1, 1'b0);
        acks(2);
        check("R6 drained / R7 extra ack", 1'b0, 2'd0, 1'b0);
        edges(1998);
        check("R7 next expiry gives fill 1", 1'b1, 2'd1, 1'b0);

        // R8: ack held across an expiry edge while empty
        restart(11'd4, 1'b1);
        edges(8);
        acks(4);
        check("R8 expiry with ack on empty", 1'b1, 2'd1, 1'b0);

        // R8: expiry and ack together with nonzero count
        restart(11'd4, 1'b1);
        edges(23);
        acks(1);
        check("R8 hold at 5", 1'b1, 2'd2, 1'b0);

        // R9: overflow survives an acknowledge
        restart(11'd4, 1'b1);
        edges(32);
        acks(1);
        check("R9 sticky after ack", 1'b1, 2'd2, 1'b1);

        // R1: a second reset clears overflow
        restart(11'd4, 1'b1);
        check("R1 after reset", 1'b0, 2'd0, 1'b0);

        // R10: request and urgency agree on a fresh expiry with queue off
        restart(11'd4, 1'b0);
        edges(4);
        check("R10 req with prio", 1'b1, 2'd3, 1'b0);

        summary();
    end
endmodule